// File: doc/BRIEF.md
# Dual-Channel Output Compare Unit

This block compares a 16-bit free-running timer value, supplied from outside, against two programmable compare registers. Every compare hit inverts a channel output, latches a sticky hit flag and, if that channel's interrupt enable is set, drives an interrupt request. Each channel has an enable that hands its pin from general-purpose port control to the compare output. The block also has a level field that software can write directly while comparison is halted.

A pairing mode lets the channel 1 output invert on hits from both compare registers. This makes a pulse that starts at compare 0 and ends at compare 1. Software reaches the control/status word and both compare registers through a simple synchronous register bus. A side-band input marks reads that belong to a read-modify-write access.

Top module: `ocu_top`

## Requirements
- R1: After synchronous reset, both outputs, both pin enables, both interrupts and every register read as 0.
- R2: With the pairing bit (control bit 12) at 0 and run (bit 0) at 1, output 0 inverts on a compare 0 hit and output 1 inverts on a compare 1 hit. The inversion is visible one clock after the cycle in which the timer input equals the register.
- R3: With the pairing bit at 1, output 0 still inverts only on compare 0 hits, while output 1 inverts on compare 0 hits and again on compare 1 hits.
- R4: With the pairing bit at 1 and both compare registers holding the same value, a coincident hit inverts output 1 once, not twice.
- R5: A hit is taken only in the first cycle of equality. A timer input that stays at the matching value causes no further inversion and no further flag setting.
- R6: While run is 0, no hit is detected: outputs and flags stay unchanged apart from software writes.
- R7: Control bits 11:10 (bit 11 channel 1, bit 10 channel 0) appear unchanged on the pin enable outputs.
- R8: A control write sets the outputs to bits 9:8 only while run is 0. While run is 1 those bits are ignored. Reads of bits 9:8 return the present outputs.
- R9: A hit sets its flag (bits 7:6, bit 7 channel 1). Each interrupt output equals its flag ANDed with its enable (bits 5:4, bit 5 channel 1).
- R10: Writing 0 to a flag clears it and writing 1 leaves it unchanged. A hit in the same cycle as a clearing write leaves the flag set.
- R11: A control read with the read-modify-write input high returns 1 in bits 7:6, whatever the flags are.
- R12: Address 0 is the control word, address 1 is compare 0 and address 2 is compare 1. Address 3 and the unused control bits 15:13 and 3:1 read 0. Read data is 0 when no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_val | input | 16 | Current free-running timer value |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_rmw | input | 1 | Read belongs to a read-modify-write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data |
| pin_en | output | 2 | Per-channel output routing enable |
| pin_out | output | 2 | Compare output levels |
| irq | output | 2 | Per-channel interrupt requests |

## Verification
A bad edge-detect register shows up at the outputs within one clock as an extra or missing inversion while the timer sits on a compare value. A bad flag shows on `irq` in the same clock, or on the next status read. Because every later inversion continues from the present level, a single wrong toggle leaves the output inverted until software rewrites it. The cycle-by-cycle output comparison therefore catches it on the first clock after the fault and on every clock until the level is rewritten. Pairing-mode faults show only on output 1, so they are caught only by hit sequences in which both registers are visited and by sequences in which the two registers are equal.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    localparam int TMR_W  = 16;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int N_CH   = 2;

    localparam int POS_PAIR = 12;
    localparam int POS_OE   = 10;
    localparam int POS_LVL  = 8;
    localparam int POS_FLG  = 6;
    localparam int POS_IE   = 4;
    localparam int POS_RUN  = 0;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CMP0 = 2'd1,
        REG_CMP1 = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       pair;
        logic [1:0] oe;
        logic [1:0] ie;
        logic       run;
    } cfg_t;

    // Inversion vector for both outputs from the per-channel hit events.
    // OR-ing the two events makes a coincident hit count only once.
    function automatic logic [1:0] flip_vec(input logic pair, input logic [1:0] hit_ev);
        logic [1:0] f;
        f[0] = hit_ev[0];
        f[1] = pair ? (hit_ev[0] | hit_ev[1]) : hit_ev[1];
        return f;
    endfunction

endpackage

// File: rtl/ocu_match.sv
module ocu_match #(
    parameter int TW = ocu_pkg::TMR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] tmr,
    input  logic          cmp_wr,
    input  logic [TW-1:0] cmp_wdata,
    output logic [TW-1:0] cmp_q,
    output logic          hit_ev
);
    logic eq_now;
    logic eq_q;

    assign eq_now = (tmr == cmp_q);
    assign hit_ev = run && eq_now && !eq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            eq_q  <= 1'b0;
        end else begin
            eq_q <= eq_now;
            if (cmp_wr)
                cmp_q <= cmp_wdata;
        end
    end
endmodule

// File: rtl/ocu_csr.sv
module ocu_csr
    import ocu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    hit_ev,
    output cfg_t          cfg_q,
    output logic [1:0]    lvl_q,
    output logic [1:0]    flg_q
);
    logic [1:0] flips;
    logic [1:0] keep_mask;
    logic       unused_bits;

    assign flips       = flip_vec(cfg_q.pair, hit_ev);
    assign keep_mask   = wr_ctrl ? wdata[POS_FLG +: 2] : 2'b11;
    assign unused_bits = ^{wdata[DW-1:POS_PAIR+1], wdata[POS_IE-1:POS_RUN+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            lvl_q <= '0;
            flg_q <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg_q.pair <= wdata[POS_PAIR];
                cfg_q.oe   <= wdata[POS_OE +: 2];
                cfg_q.ie   <= wdata[POS_IE +: 2];
                cfg_q.run  <= wdata[POS_RUN];
            end
            if (wr_ctrl && !cfg_q.run)
                lvl_q <= wdata[POS_LVL +: 2];
            else
                lvl_q <= lvl_q ^ flips;
            flg_q <= (flg_q & keep_mask) | hit_ev;
        end
    end
endmodule

// File: rtl/ocu_top.sv
module ocu_top
    import ocu_pkg::*;
#(
    parameter int TW = TMR_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NC = N_CH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] tmr_val,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_rmw,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [NC-1:0] pin_en,
    output logic [NC-1:0] pin_out,
    output logic [NC-1:0] irq
);
    cfg_t          cfg_q;
    logic [1:0]    lvl_q;
    logic [1:0]    flg_q;
    logic [NC-1:0] hit_ev;
    logic [TW-1:0] cmp_q [NC];
    logic          run_w;
    logic          pair_w;
    logic          wr_ctrl;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == AW'(REG_CTRL));
    assign run_w   = cfg_q.run;
    assign pair_w  = cfg_q.pair;

    for (genvar g = 0; g < NC; g++) begin : g_ch
        ocu_match #(.TW(TW)) u_match (
            .clk       (clk),
            .rst       (rst),
            .run       (cfg_q.run),
            .tmr       (tmr_val),
            .cmp_wr    (bus_sel && bus_wr && (bus_addr == AW'(g + 1))),
            .cmp_wdata (bus_wdata[TW-1:0]),
            .cmp_q     (cmp_q[g]),
            .hit_ev    (hit_ev[g])
        );
    end

    ocu_csr #(.DW(DW)) u_csr (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wdata   (bus_wdata),
        .hit_ev  (hit_ev),
        .cfg_q   (cfg_q),
        .lvl_q   (lvl_q),
        .flg_q   (flg_q)
    );

    assign pin_en  = cfg_q.oe;
    assign pin_out = lvl_q;
    assign irq     = flg_q & cfg_q.ie;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (reg_sel_e'(bus_addr))
                REG_CTRL: begin
                    bus_rdata[POS_PAIR]     = cfg_q.pair;
                    bus_rdata[POS_OE +: 2]  = cfg_q.oe;
                    bus_rdata[POS_LVL +: 2] = lvl_q;
                    bus_rdata[POS_FLG +: 2] = flg_q | {2{bus_rmw}};
                    bus_rdata[POS_IE +: 2]  = cfg_q.ie;
                    bus_rdata[POS_RUN]      = cfg_q.run;
                end
                REG_CMP0: bus_rdata[TW-1:0] = cmp_q[0];
                REG_CMP1: bus_rdata[TW-1:0] = cmp_q[1];
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ocu_top_chk.sv
module ocu_top_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] tmr_val,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic        bus_rmw,
    input logic [1:0]  bus_addr,
    input logic [15:0] bus_rdata,
    input logic [1:0]  pin_out,
    input logic        run,
    input logic        pair,
    input logic [1:0]  ev,
    input logic [1:0]  flag
);
    assert_rmw_flags_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_rmw && bus_addr == 2'd0) |-> (bus_rdata[7:6] == 2'b11));

    assert_stopped_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!run && !(bus_sel && bus_wr)) |=> $stable(pin_out));

    assert_single_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (pair && ev == 2'b11) |=> (pin_out[1] != $past(pin_out[1])));

    assert_held_timer_R5: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(tmr_val) && !bus_wr && !$past(bus_wr)) |=> $stable(pin_out));

    assert_set_wins0_R10: assert property (@(posedge clk) disable iff (rst)
        ev[0] |=> flag[0]);

    assert_set_wins1_R10: assert property (@(posedge clk) disable iff (rst)
        ev[1] |=> flag[1]);

    assert_flag_source0_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[0]) |-> $past(ev[0]));

    assert_flag_source1_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[1]) |-> $past(ev[1]));
endmodule

bind ocu_top ocu_top_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tmr_val   (tmr_val),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rmw   (bus_rmw),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .run       (run_w),
    .pair      (pair_w),
    .ev        (hit_ev),
    .flag      (flg_q)
);

// File: tb/ocu_top_test.sv
module ocu_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tmr_val = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rmw = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  pin_en, pin_out, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model of the register state
    logic [15:0] m_c0 = '0, m_c1 = '0;
    logic        m_pair = 0, m_run = 0;
    logic [1:0]  m_oe = 0, m_ie = 0, m_lvl = 0, m_flg = 0, m_eq = 0;

    always #2 clk = ~clk;

    ocu_top uut (
        .clk(clk), .rst(rst), .tmr_val(tmr_val), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rmw(bus_rmw), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_en(pin_en), .pin_out(pin_out), .irq(irq)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [1:0] a, input logic rmw);
        logic [15:0] v = '0;
        case (a)
            2'd0: begin
                v[12] = m_pair; v[11:10] = m_oe; v[9:8] = m_lvl;
                v[7:6] = rmw ? 2'b11 : m_flg; v[5:4] = m_ie; v[0] = m_run;
            end
            2'd1: v = m_c0;
            2'd2: v = m_c1;
            default: v = '0;
        endcase
        return v;
    endfunction

    // one clock: drive at negedge, check read data, advance model, check outputs at next negedge
    task automatic cycle(input logic [15:0] t, input logic s, input logic w, input logic r,
                         input logic [1:0] a, input logic [15:0] d, input string tag);
        logic [1:0] ev, fl;
        tmr_val = t; bus_sel = s; bus_wr = w; bus_rmw = r; bus_addr = a; bus_wdata = d;
        #1;
        if (s && !w) check(bus_rdata, exp_read(a, r), {tag, " read"});
        else check(bus_rdata, 16'h0, {tag, " idle read"});
        ev[0] = m_run && (t == m_c0) && !m_eq[0];
        ev[1] = m_run && (t == m_c1) && !m_eq[1];
        fl[0] = ev[0];
        fl[1] = m_pair ? (ev[0] || ev[1]) : ev[1];
        m_eq = {t == m_c1, t == m_c0};
        if (s && w && a == 2'd0 && !m_run) m_lvl = d[9:8];
        else m_lvl = m_lvl ^ fl;
        m_flg = ((s && w && a == 2'd0) ? (m_flg & d[7:6]) : m_flg) | ev;
        if (s && w && a == 2'd0) begin
            m_pair = d[12]; m_oe = d[11:10]; m_ie = d[5:4]; m_run = d[0];
        end
        if (s && w && a == 2'd1) m_c0 = d;
        if (s && w && a == 2'd2) m_c1 = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_rmw = 1'b0;
        check({14'h0, pin_out}, {14'h0, m_lvl}, {tag, " pin_out"});
        check({14'h0, pin_en}, {14'h0, m_oe}, {tag, " pin_en (R7)"});
        check({14'h0, irq}, {14'h0, m_flg & m_ie}, {tag, " irq (R9)"});
    endtask

    task automatic idle(input logic [15:0] t, input string tag);
        cycle(t, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, tag);
    endtask

    task automatic wr(input logic [15:0] t, input logic [1:0] a, input logic [15:0] d, input string tag);
        cycle(t, 1'b1, 1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd(input logic [15:0] t, input logic [1:0] a, input logic r, input string tag);
        cycle(t, 1'b1, 1'b0, r, a, 16'h0, tag);
    endtask

    initial begin
        #1200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] p;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check({14'h0, pin_out}, 16'h0, "R1 pin_out");
        check({14'h0, irq}, 16'h0, "R1 irq");
        rd(16'h0, 2'd0, 1'b0, "R1");
        rd(16'h0, 2'd1, 1'b0, "R1");
        // R12 map
        wr(16'h0, 2'd1, 16'h0100, "R12");
        wr(16'h0, 2'd2, 16'h0200, "R12");
        rd(16'h0, 2'd1, 1'b0, "R12");
        rd(16'h0, 2'd2, 1'b0, "R12");
        rd(16'h0, 2'd3, 1'b0, "R12");
        // R8 level write while stopped, R7 enables
        wr(16'h0, 2'd0, 16'h0F00, "R8");
        check({14'h0, pin_out}, 16'h3, "R8 forced level");
        check({14'h0, pin_en}, 16'h3, "R7 enables");
        rd(16'h0, 2'd0, 1'b0, "R8");
        // run, mode 0
        wr(16'h0, 2'd0, 16'hE0F1, "R12");
        check({14'h0, pin_out}, 16'h0, "R8 level 0");
        idle(16'h00FF, "R2");
        idle(16'h0100, "R2");
        check({14'h0, pin_out}, 16'h1, "R2 ch0 flip");
        check({14'h0, irq}, 16'h1, "R9 flag0");
        repeat (3) idle(16'h0100, "R5");
        check({14'h0, pin_out}, 16'h1, "R5 no repeat");
        wr(16'h0100, 2'd0, 16'h0FF1, "R8");
        check({14'h0, pin_out}, 16'h1, "R8 ignored while running");
        idle(16'h0200, "R2");
        check({14'h0, pin_out}, 16'h3, "R2 ch1 flip");
        rd(16'h0200, 2'd0, 1'b1, "R11");
        rd(16'h0200, 2'd0, 1'b0, "R11");
        // R10 clear, write-1 no effect, set wins
        wr(16'h0200, 2'd0, 16'h0CB1, "R10");
        check({14'h0, irq}, 16'h2, "R10 clear flag0");
        wr(16'h0200, 2'd0, 16'h0CF1, "R10");
        check({14'h0, irq}, 16'h2, "R10 write one");
        idle(16'h0000, "R10");
        wr(16'h0200, 2'd0, 16'h0C31, "R10");
        check({14'h0, irq}, 16'h2, "R10 set wins");
        // R3 pairing mode
        wr(16'h0000, 2'd0, 16'h1CF1, "R3");
        p = pin_out;
        idle(16'h0100, "R3");
        check({14'h0, pin_out}, {14'h0, p ^ 2'b11}, "R3 cmp0 flips both");
        p = pin_out;
        idle(16'h0200, "R3");
        check({14'h0, pin_out}, {14'h0, p ^ 2'b10}, "R3 cmp1 flips ch1");
        // R4 equal registers
        wr(16'h0000, 2'd2, 16'h0100, "R4");
        p = pin_out;
        idle(16'h0100, "R4");
        check({14'h0, pin_out}, {14'h0, p ^ 2'b11}, "R4 single flip");
        // R6 stopped
        wr(16'h0000, 2'd0, 16'h1C30, "R6");
        p = pin_out;
        idle(16'h0100, "R6");
        idle(16'h0200, "R6");
        check({14'h0, pin_out}, {14'h0, p}, "R6 no flip");
        check({14'h0, irq}, 16'h0, "R6 no flag");
        wr(16'h0000, 2'd0, 16'h0C31, "R9");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] t;
            int k;
            k = $urandom_range(0, 3);
            t = (k == 0) ? m_c0 : (k == 1) ? m_c1 : (k == 2) ? tmr_val + 16'd1 : 16'($urandom);
            if ($urandom_range(0, 9) == 0) begin
                logic [1:0] a;
                logic [15:0] d;
                a = 2'($urandom_range(0, 3));
                d = 16'($urandom);
                if (a == 2'd0 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
                if (a != 2'd0) d = {8'h0, d[7:0]};
                wr(t, a, d, "R9");
            end else if ($urandom_range(0, 4) == 0) begin
                rd(t, 2'($urandom_range(0, 3)), 1'($urandom), "R11");
            end else begin
                idle(t, "R9");
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule